// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block lives on the device side of a synchronous DRAM model. When a read or write command is registered, it captures a starting column and a burst-length code. It then presents one column address per clock for the length of the burst. The memory array reads or writes each beat at that address.

Fixed-length bursts of 1, 2, 4 or 8 beats wrap inside an aligned block of their own size. A full-page burst walks the whole 256-column row and keeps wrapping until a terminate request or a new command stops it. A new column command is accepted on any cycle and replaces the burst in progress.

On the final beat of a fixed-length burst the block raises a one-cycle end pulse. If the command asked for auto precharge, it also raises a precharge-start pulse so the bank logic can close the row on its own. While the clock enable is low the block freezes: nothing advances, nothing is accepted, and no beat is reported.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, beatValid, endBurst, prechargeStart and beatWrite are 0 and colAddr is 0.
- R2: A cycle with clkEn high and cmdRead or cmdWrite high starts a burst. In the next cycle (with clkEn high) beatValid is 1, colAddr equals the captured startCol, and beatWrite equals the captured cmdWrite.
- R3: lenCode is captured with the command. 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives full page. The unused codes 4, 5 and 6 give a single beat.
- R4: In a fixed burst of length L, each new beat keeps the column bits above log2(L) and increments the low log2(L) bits modulo L.
- R5: A full-page burst increments the column modulo 256, so 255 is followed by 0. It continues without limit until terminated or replaced.
- R6: endBurst is high for exactly the one cycle of the final beat of a fixed burst. It is never raised in full-page mode, nor for a burst that is terminated or replaced before its final beat.
- R7: autoPre is captured with the command. prechargeStart is high exactly when endBurst is high and the captured autoPre was 1.
- R8: A command arriving during a burst, including on its final beat, replaces it. The next beat is the new startCol with the new length, direction and autoPre.
- R9: termReq with clkEn high and no command keeps the current beat valid and ends the burst from the next cycle, with no endBurst. A command in the same cycle takes priority over termReq. termReq while idle has no effect.
- R10: While clkEn is low, beatValid, endBurst and prechargeStart are 0. colAddr and burst progress are held, and commands and termReq are ignored. The burst resumes where it stopped once clkEn returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEn | input | 1 | Clock enable; low suspends the burst |
| cmdRead | input | 1 | Read command strobe |
| cmdWrite | input | 1 | Write command strobe |
| autoPre | input | 1 | Auto precharge request sampled with the command |
| startCol | input | 8 | Starting column sampled with the command |
| lenCode | input | 3 | Burst-length code sampled with the command |
| termReq | input | 1 | Burst terminate request |
| colAddr | output | 8 | Column address of the current beat |
| beatValid | output | 1 | A burst beat is present this cycle |
| beatWrite | output | 1 | Current beat belongs to a write burst |
| endBurst | output | 1 | Final beat of a fixed-length burst |
| prechargeStart | output | 1 | Start self-timed precharge (end of an auto-precharge burst) |

## Verification
The case of interest is a command on the final beat of a fixed burst. In that cycle the end pulse, and possibly the precharge pulse, must fire for the old burst, while the new start column is captured for the next cycle.

A directed sequence places a command on exactly that beat, and another places a terminate request together with a command. Random stimulus then produces many more such overlaps. A cycle model in the bench judges every cycle's valid flag, column, direction and both pulses, so a pulse that is lost or doubled in the overlap cycle is caught.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  // Default geometry of one row: 8 column bits, 256 columns.
  localparam int unsigned COL_BITS = 8;
  // Width of the burst-length code.
  localparam int unsigned LEN_BITS = 3;
  // log2 of the longest fixed burst (8 beats).
  localparam int unsigned FIXED_MAX_LOG = 3;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;   // capture a new start column
    logic step;   // move to the next column of the burst
  } colStrobe_t;

endpackage

// File: rtl/colgen_ctrl.sv
module colgen_ctrl
  import colgen_pkg::*;
#(
  parameter int unsigned ColW        = COL_BITS,
  parameter int unsigned LenW        = LEN_BITS,
  parameter int unsigned FixedMaxLog = FIXED_MAX_LOG
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            clkEn,
  input  logic            cmdRead,
  input  logic            cmdWrite,
  input  logic            autoPre,
  input  logic [LenW-1:0] lenCode,
  input  logic            termReq,
  output colStrobe_t      strobe,
  output logic [ColW-1:0] wrapMask,
  output logic            beatValid,
  output logic            beatWrite,
  output logic            endBurst,
  output logic            prechargeStart
);

  localparam int unsigned CntW = (FixedMaxLog < 1) ? 1 : FixedMaxLog;
  localparam logic [LenW-1:0] PageCode = '1;

  logic            activeQ;
  logic            pageQ;
  logic            apQ;
  logic            wrQ;
  logic [CntW-1:0] remainQ;
  logic [ColW-1:0] maskQ;

  logic            cmdHit;
  logic            lastBeat;
  logic [ColW-1:0] maskNext;
  logic            pageNext;

  // Length code to wrap mask: a fixed burst of 2^k beats gets k ones,
  // the page code gets all ones, any unused code gets a single beat.
  always_comb begin
    pageNext = (lenCode == PageCode);
    maskNext = '0;
    if (pageNext) begin
      maskNext = '1;
    end else if (int'(lenCode) <= int'(FixedMaxLog)) begin
      for (int b = 0; b < int'(ColW); b++) begin
        maskNext[b] = (b < int'(lenCode));
      end
    end
  end

  assign cmdHit   = clkEn & (cmdRead | cmdWrite);
  assign lastBeat = activeQ & ~pageQ & (remainQ == '0);

  assign strobe.load = cmdHit;
  assign strobe.step = clkEn & activeQ & ~cmdHit & ~termReq & ~lastBeat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      pageQ   <= 1'b0;
      apQ     <= 1'b0;
      wrQ     <= 1'b0;
      remainQ <= '0;
      maskQ   <= '0;
    end else if (clkEn) begin
      if (cmdHit) begin
        activeQ <= 1'b1;
        pageQ   <= pageNext;
        apQ     <= autoPre;
        wrQ     <= cmdWrite;
        remainQ <= maskNext[CntW-1:0];
        maskQ   <= maskNext;
      end else if (termReq) begin
        activeQ <= 1'b0;
      end else if (activeQ) begin
        if (lastBeat) begin
          activeQ <= 1'b0;
        end else begin
          remainQ <= remainQ - CntW'(1);
        end
      end
    end
  end

  assign wrapMask       = maskQ;
  assign beatValid      = activeQ & clkEn;
  assign beatWrite      = beatValid & wrQ;
  assign endBurst       = beatValid & lastBeat;
  assign prechargeStart = endBurst & apQ;

  // Suspend freezes all burst progress.
  assert_suspend_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> ($stable(activeQ) && $stable(remainQ) && $stable(maskQ)));

  // Final beat without a fresh command closes the burst.
  assert_end_closes_R6: assert property (@(posedge clk) disable iff (!rstN)
    (endBurst && !cmdHit) |=> !activeQ);

  // A command always opens a burst for the next cycle.
  assert_cmd_opens_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmdHit |=> activeQ);

  // Terminate without a command stops the burst.
  assert_term_stops_R9: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && termReq && !cmdHit) |=> !activeQ);

  // A full-page burst never ends by itself.
  assert_page_runs_R5: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && activeQ && pageQ && !termReq && !cmdHit) |=> activeQ);

  // Precharge start only with a valid beat.
  assert_pre_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    prechargeStart |-> (beatValid && clkEn));

endmodule

// File: rtl/colgen_datapath.sv
module colgen_datapath
  import colgen_pkg::*;
#(
  parameter int unsigned ColW = COL_BITS
) (
  input  logic            clk,
  input  logic            rstN,
  input  colStrobe_t      strobe,
  input  logic [ColW-1:0] startCol,
  input  logic [ColW-1:0] wrapMask,
  output logic [ColW-1:0] colAddr
);

  logic [ColW-1:0] colQ;
  logic [ColW-1:0] colInc;
  logic [ColW-1:0] colStep;

  // Bits under the mask count, bits above it stay put.
  assign colInc  = colQ + ColW'(1);
  assign colStep = (colQ & ~wrapMask) | (colInc & wrapMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colQ <= '0;
    end else if (strobe.load) begin
      colQ <= startCol;
    end else if (strobe.step) begin
      colQ <= colStep;
    end
  end

  assign colAddr = colQ;

  // Column bits outside the wrap window never change on a step.
  assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load) |=> (((colQ ^ $past(colQ)) & ~$past(wrapMask)) == '0));

  // Page wrap: last column goes back to zero.
  assert_page_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load && (wrapMask == '1) && (colQ == '1)) |=> (colQ == '0));

  // Load presents the requested column.
  assert_load_col_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (colQ == $past(startCol)));

  // Idle strobes leave the column alone.
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.step) |=> $stable(colQ));

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int unsigned ColW        = COL_BITS,
  parameter int unsigned LenW        = LEN_BITS,
  parameter int unsigned FixedMaxLog = FIXED_MAX_LOG
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            clkEn,
  input  logic            cmdRead,
  input  logic            cmdWrite,
  input  logic            autoPre,
  input  logic [ColW-1:0] startCol,
  input  logic [LenW-1:0] lenCode,
  input  logic            termReq,
  output logic [ColW-1:0] colAddr,
  output logic            beatValid,
  output logic            beatWrite,
  output logic            endBurst,
  output logic            prechargeStart
);

  colStrobe_t      strobe;
  logic [ColW-1:0] wrapMask;

  colgen_ctrl #(
    .ColW        (ColW),
    .LenW        (LenW),
    .FixedMaxLog (FixedMaxLog)
  ) i_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .clkEn          (clkEn),
    .cmdRead        (cmdRead),
    .cmdWrite       (cmdWrite),
    .autoPre        (autoPre),
    .lenCode        (lenCode),
    .termReq        (termReq),
    .strobe         (strobe),
    .wrapMask       (wrapMask),
    .beatValid      (beatValid),
    .beatWrite      (beatWrite),
    .endBurst       (endBurst),
    .prechargeStart (prechargeStart)
  );

  colgen_datapath #(
    .ColW (ColW)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .startCol (startCol),
    .wrapMask (wrapMask),
    .colAddr  (colAddr)
  );

endmodule

// File: tb/test_sdram_burst_colgen.sv
module test_sdram_burst_colgen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clkEn = 1'b0;
  logic       cmdRead = 1'b0;
  logic       cmdWrite = 1'b0;
  logic       autoPre = 1'b0;
  logic [7:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic       termReq = 1'b0;
  logic [7:0] colAddr;
  logic       beatValid, beatWrite, endBurst, prechargeStart;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string scen = "R1";

  // model state
  bit mActive = 0;
  int mCol = 0;
  int mLeft = 0;
  int mLen = 1;   // 0 means full page
  bit mAp = 0;
  bit mWr = 0;

  always #10 clk = ~clk;  // 50 MHz

  sdram_burst_colgen i_sdram_burst_colgen (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .cmdRead(cmdRead), .cmdWrite(cmdWrite),
    .autoPre(autoPre), .startCol(startCol), .lenCode(lenCode), .termReq(termReq),
    .colAddr(colAddr), .beatValid(beatValid), .beatWrite(beatWrite),
    .endBurst(endBurst), .prechargeStart(prechargeStart)
  );

  // R3: code to beat count, 0 = full page
  function automatic int lenOf(input logic [2:0] c);
    case (c)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int nextCol(input int c, input int l);
    if (l == 0) return (c + 1) % 256;
    return (c / l) * l + ((c % l) + 1) % l;
  endfunction

  task automatic chk(input string req, input int got, input int exp, input string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s (%s) %s: actual=%0d expected=%0d", req, scen, what, got, exp);
    end
  endtask

  task automatic checkOutputs();
    bit v, e;
    v = mActive && clkEn;
    e = v && (mLen != 0) && (mLeft == 0);
    chk(clkEn ? "R2" : "R10", int'(beatValid), int'(v), "beatValid");
    chk(mLen == 0 ? "R5" : "R4", int'(colAddr), mCol, "colAddr");
    chk("R6", int'(endBurst), int'(e), "endBurst");
    chk("R7", int'(prechargeStart), int'(e && mAp), "prechargeStart");
    chk("R2", int'(beatWrite), int'(v && mWr), "beatWrite");
  endtask

  task automatic modelEdge();
    if (!clkEn) return;
    if (cmdRead || cmdWrite) begin
      mActive = 1; mCol = int'(startCol); mLen = lenOf(lenCode);
      mLeft = (mLen == 0) ? 0 : mLen - 1; mAp = autoPre; mWr = cmdWrite;
    end else if (termReq) begin
      mActive = 0;
    end else if (mActive) begin
      if (mLen != 0 && mLeft == 0) mActive = 0;
      else begin
        mCol = nextCol(mCol, mLen);
        if (mLen != 0) mLeft--;
      end
    end
  endtask

  // apply inputs, judge this cycle, then advance one edge
  task automatic step(input bit ce, input bit rd, input bit wr, input bit ap,
                      input int col, input int code, input bit term);
    clkEn = ce; cmdRead = rd; cmdWrite = wr; autoPre = ap;
    startCol = 8'(col); lenCode = 3'(code); termReq = term;
    #1;
    checkOutputs();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    clkEn = 1'b1;
    #1;
    scen = "R1";
    checkOutputs();

    // R3: every length code, fixed bursts wrap within their block (R4)
    scen = "R3";
    for (int c = 0; c < 8; c++) begin
      if (c == 7) continue;
      step(1, 1, 0, 0, 8'h5d, c, 0);
      idle(10);
    end

    // R5: page wrap past 255, then terminate (R9)
    scen = "R5";
    step(1, 0, 1, 1, 254, 7, 0);
    idle(5);
    scen = "R9";
    step(1, 0, 0, 0, 0, 0, 1);
    idle(3);
    step(1, 0, 0, 0, 0, 0, 1);      // term while idle
    idle(1);

    // R8: new command on the final beat, with auto precharge (R7)
    scen = "R8";
    step(1, 0, 1, 1, 5, 1, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 40, 2, 0);     // overlaps final beat of previous
    idle(2);
    step(1, 0, 1, 1, 100, 3, 0);    // mid-burst replace
    idle(10);

    // R9: command and terminate together
    scen = "R9";
    step(1, 1, 0, 0, 30, 2, 0);
    step(1, 0, 1, 0, 77, 1, 1);
    idle(4);

    // R10: suspend mid-burst with commands and terminate ignored
    scen = "R10";
    step(1, 1, 0, 1, 16, 2, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 1, 1, 0, 200, 3, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    idle(5);

    // random mix
    scen = "RND";
    for (int i = 0; i < 4000; i++) begin
      bit ce, cmd, wr, term, ap;
      int code;
      ce   = ($urandom % 10) != 0;
      cmd  = ($urandom % 8) == 0;
      wr   = $urandom % 2;
      term = ($urandom % 20) == 0;
      ap   = $urandom % 2;
      code = $urandom % 8;
      step(ce, cmd && !wr, cmd && wr, ap, $urandom % 256, code, term);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule